// File: doc/BRIEF.md
# Compact Instruction Word Decoder

This block takes one 16-bit instruction halfword per strobe and sorts it into one of three encoding formats, selected by its two most significant bits. For each format it pulls out the opcode, the register fields and the short immediate at that format's own positions. It also reports several properties of the word:

- whether the encoding is a hole in the opcode space;
- whether a 32-bit big-endian literal follows the halfword, which makes the instruction 6 bytes long instead of 2;
- whether the word is a breakpoint, a software trap or a no-op;
- which memory addressing class a long-format load or store uses.

A fetch stage places the halfword on `in_word` with `in_valid` high. The decoded result appears on the registered outputs one clock later. Between strobes the outputs keep the last decoded word. Reading the trailing literal and executing the instruction are left to the stages around this block.

Top module: `halfword_decoder`

## Requirements
- R1: `out_form` reports 1 when bit 15 of the word is 0, 2 when bits 15:14 are 10, and 3 when bits 15:14 are 11.
- R2: For form 1, `out_opcode` is bits 15:8, `out_reg_a` is bits 7:4, `out_reg_b` is bits 3:0, and `out_imm8` is 0.
- R3: For form 2, `out_opcode` is bits 13:12 zero-extended, `out_reg_a` is bits 11:8, `out_imm8` is bits 7:0, and `out_reg_b` is 0. No form-2 word is illegal.
- R4: For form 3, `out_opcode` is the branch condition in bits 13:10 zero-extended, and both register fields and `out_imm8` are 0. The word is illegal when the condition exceeds 9.
- R5: A form-1 opcode is illegal when it is 0x00, lies in 0x10..0x18, or exceeds 0x39. All other form-1 opcodes are legal.
- R6: `out_len` is 6 for the legal form-1 opcodes 0x01, 0x03, 0x08, 0x09, 0x0C, 0x0D, 0x1A, 0x1B, 0x1D, 0x1F, 0x20, 0x22, 0x24, 0x30 and 0x36..0x39. It is 2 for every other word, and always 2 when `out_illegal` is set.
- R7: `out_brk` is set only for form-1 opcode 0x35, `out_swi` only for 0x30, and `out_nop` only for 0x0F. At most one of the three is ever set.
- R8: `out_amode` is 1 (absolute) for form-1 opcodes 0x08, 0x09, 0x1D, 0x1F, 0x22 and 0x24. It is 2 (register-indirect) for 0x0A, 0x0B, 0x1C, 0x1E, 0x21 and 0x23. It is 3 (register plus offset) for 0x0C, 0x0D and 0x36..0x39. It is 0 for every other word.
- R9: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. When `in_valid` is low, every decoded output holds its value.
- R10: While `rst_n` is low, and after reset until the first strobe, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe: `in_word` holds a halfword to decode |
| in_word | input | 16 | Instruction halfword, most significant byte first in memory |
| out_valid | output | 1 | Decoded result refreshed this cycle |
| out_form | output | 2 | Format code 1, 2 or 3 (0 after reset) |
| out_opcode | output | 8 | Opcode or branch condition, zero-extended |
| out_reg_a | output | 4 | First register field |
| out_reg_b | output | 4 | Second register field |
| out_imm8 | output | 8 | Short immediate (form 2 only) |
| out_len | output | 3 | Instruction length in bytes, 2 or 6 |
| out_illegal | output | 1 | Encoding is a hole |
| out_brk | output | 1 | Breakpoint instruction |
| out_swi | output | 1 | Software trap instruction |
| out_nop | output | 1 | No-op instruction |
| out_amode | output | 2 | Addressing class: 0 none, 1 absolute, 2 indirect, 3 offset |

## Verification
A wrong entry in the form-1 property table shows up on the very next cycle after that opcode is strobed. It appears as a wrong length, a wrong illegal flag, a wrong trap flag or a wrong addressing class. A length error is the most damaging, because it would make the fetch stage misalign every following word. For that reason the bench sweeps all 256 upper-byte values against its own model of the opcode map. A slip in the format select or a field offset corrupts every word of that format, so a handful of table vectors per format exposes it within one cycle of the strobe. A broken hold path shows as outputs changing on an idle cycle.

// File: rtl/hwdec_pkg.sv
package hwdec_pkg;

  localparam int INSN_W    = 16;
  localparam int OPC_W     = 8;
  localparam int REG_W     = 4;
  localparam int IMM_W     = 8;
  localparam int LEN_W     = 3;
  localparam int COND_W    = 4;
  localparam int SUB_W     = 2;
  localparam int BASE_LEN  = 2;
  localparam int EXT_BYTES = 4;

  typedef enum logic [1:0] {
    FMT_NONE  = 2'd0,
    FMT_ONE   = 2'd1,
    FMT_TWO   = 2'd2,
    FMT_THREE = 2'd3
  } fmt_e;

  typedef enum logic [1:0] {
    AM_NONE = 2'd0,
    AM_ABS  = 2'd1,
    AM_IND  = 2'd2,
    AM_OFS  = 2'd3
  } amode_e;

  typedef struct packed {
    fmt_e              fmt;
    logic [OPC_W-1:0]  opc;
    logic [REG_W-1:0]  ra;
    logic [REG_W-1:0]  rb;
    logic [IMM_W-1:0]  imm;
    logic [LEN_W-1:0]  len;
    logic              ill;
    logic              brk;
    logic              swi;
    logic              nop;
    amode_e            am;
  } dec_t;

  // Holes in the long-format opcode space: zero, a reserved band, and the tail.
  function automatic logic op_is_hole(input logic [OPC_W-1:0] op,
                                      input logic [OPC_W-1:0] band_lo,
                                      input logic [OPC_W-1:0] band_hi,
                                      input logic [OPC_W-1:0] last_op);
    return (op == '0) || ((op >= band_lo) && (op <= band_hi)) || (op > last_op);
  endfunction

  // Long-format opcodes that are followed by a 32-bit literal.
  function automatic logic op_has_ext(input logic [OPC_W-1:0] op);
    case (op)
      8'h01, 8'h03, 8'h08, 8'h09, 8'h0C, 8'h0D, 8'h1A, 8'h1B,
      8'h1D, 8'h1F, 8'h20, 8'h22, 8'h24, 8'h30,
      8'h36, 8'h37, 8'h38, 8'h39: return 1'b1;
      default:                    return 1'b0;
    endcase
  endfunction

  function automatic amode_e op_amode(input logic [OPC_W-1:0] op);
    case (op)
      8'h08, 8'h09, 8'h1D, 8'h1F, 8'h22, 8'h24: return AM_ABS;
      8'h0A, 8'h0B, 8'h1C, 8'h1E, 8'h21, 8'h23: return AM_IND;
      8'h0C, 8'h0D, 8'h36, 8'h37, 8'h38, 8'h39: return AM_OFS;
      default:                                  return AM_NONE;
    endcase
  endfunction

  // Byte length; an illegal word never claims a trailing literal.
  function automatic logic [LEN_W-1:0] insn_len(input logic ext, input logic ill);
    return (ext && !ill) ? LEN_W'(BASE_LEN + EXT_BYTES) : LEN_W'(BASE_LEN);
  endfunction

  function automatic logic cond_legal(input logic [COND_W-1:0] cond,
                                      input logic [COND_W-1:0] max_cond);
    return cond <= max_cond;
  endfunction

endpackage

// File: rtl/hwdec_split.sv
module hwdec_split
  import hwdec_pkg::*;
(
  input  logic [INSN_W-1:0] word,
  output fmt_e              fmt,
  output logic [OPC_W-1:0]  op_long,
  output logic [SUB_W-1:0]  op_sub,
  output logic [COND_W-1:0] cond,
  output logic [REG_W-1:0]  f1_a,
  output logic [REG_W-1:0]  f1_b,
  output logic [REG_W-1:0]  f2_r,
  output logic [IMM_W-1:0]  f2_imm
);

  localparam int SEL_HI  = INSN_W - 1;
  localparam int SEL_LO  = INSN_W - 2;
  localparam int SUB_HI  = SEL_LO - 1;
  localparam int F2R_HI  = SUB_HI - SUB_W;

  always_comb begin
    if (!word[SEL_HI])      fmt = FMT_ONE;
    else if (!word[SEL_LO]) fmt = FMT_TWO;
    else                    fmt = FMT_THREE;
  end

  assign op_long = word[SEL_HI -: OPC_W];
  assign f1_a    = word[2*REG_W-1 -: REG_W];
  assign f1_b    = word[REG_W-1:0];
  assign op_sub  = word[SUB_HI -: SUB_W];
  assign f2_r    = word[F2R_HI -: REG_W];
  assign f2_imm  = word[IMM_W-1:0];
  assign cond    = word[SUB_HI -: COND_W];

endmodule

// File: rtl/hwdec_f1_table.sv
module hwdec_f1_table
  import hwdec_pkg::*;
#(
  parameter logic [OPC_W-1:0] BAND_LO = 8'h10,
  parameter logic [OPC_W-1:0] BAND_HI = 8'h18,
  parameter logic [OPC_W-1:0] LAST_OP = 8'h39,
  parameter logic [OPC_W-1:0] BRK_OP  = 8'h35,
  parameter logic [OPC_W-1:0] SWI_OP  = 8'h30,
  parameter logic [OPC_W-1:0] NOP_OP  = 8'h0F
) (
  input  logic [OPC_W-1:0] op,
  output logic             ill,
  output logic             ext,
  output logic             brk,
  output logic             swi,
  output logic             nop,
  output amode_e           am
);

  localparam int DEPTH  = 1 << OPC_W;
  localparam int ATTR_W = 5 + $bits(amode_e);

  logic [ATTR_W-1:0] attr_rom [DEPTH];

  // One constant attribute word per opcode, computed at elaboration.
  for (genvar g = 0; g < DEPTH; g++) begin : g_attr
    localparam logic [OPC_W-1:0] OPV = OPC_W'(g);
    assign attr_rom[g] = { op_is_hole(OPV, BAND_LO, BAND_HI, LAST_OP),
                           op_has_ext(OPV),
                           (OPV == BRK_OP),
                           (OPV == SWI_OP),
                           (OPV == NOP_OP),
                           op_amode(OPV) };
  end

  logic [ATTR_W-1:0] hit;
  assign hit = attr_rom[op];

  assign ill = hit[ATTR_W-1];
  assign ext = hit[ATTR_W-2];
  assign brk = hit[ATTR_W-3];
  assign swi = hit[ATTR_W-4];
  assign nop = hit[ATTR_W-5];
  assign am  = amode_e'(hit[$bits(amode_e)-1:0]);

endmodule

// File: rtl/hwdec_outreg.sv
module hwdec_outreg
  import hwdec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  dec_t d,
  output logic out_valid,
  output dec_t q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      q         <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) q <= d;
    end
  end

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);                                        // R9
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);                                      // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(q));                                      // R9
  AST_ILL_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    q.ill |-> (q.len == LEN_W'(BASE_LEN)));                         // R6

endmodule

// File: rtl/halfword_decoder.sv
module halfword_decoder
  import hwdec_pkg::*;
#(
  parameter logic [COND_W-1:0] MAX_COND = 4'd9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [15:0] in_word,
  output logic        out_valid,
  output logic [1:0]  out_form,
  output logic [7:0]  out_opcode,
  output logic [3:0]  out_reg_a,
  output logic [3:0]  out_reg_b,
  output logic [7:0]  out_imm8,
  output logic [2:0]  out_len,
  output logic        out_illegal,
  output logic        out_brk,
  output logic        out_swi,
  output logic        out_nop,
  output logic [1:0]  out_amode
);

  fmt_e              sp_fmt;
  logic [OPC_W-1:0]  sp_op_long;
  logic [SUB_W-1:0]  sp_op_sub;
  logic [COND_W-1:0] sp_cond;
  logic [REG_W-1:0]  sp_f1_a, sp_f1_b, sp_f2_r;
  logic [IMM_W-1:0]  sp_f2_imm;

  hwdec_split u_split (
    .word    (in_word),
    .fmt     (sp_fmt),
    .op_long (sp_op_long),
    .op_sub  (sp_op_sub),
    .cond    (sp_cond),
    .f1_a    (sp_f1_a),
    .f1_b    (sp_f1_b),
    .f2_r    (sp_f2_r),
    .f2_imm  (sp_f2_imm)
  );

  logic   tb_ill, tb_ext, tb_brk, tb_swi, tb_nop;
  amode_e tb_am;

  hwdec_f1_table u_table (
    .op  (sp_op_long),
    .ill (tb_ill),
    .ext (tb_ext),
    .brk (tb_brk),
    .swi (tb_swi),
    .nop (tb_nop),
    .am  (tb_am)
  );

  // Named internal events.
  logic f1_hole_hit, f3_cond_bad, ext_follows;
  assign f1_hole_hit = (sp_fmt == FMT_ONE) && tb_ill;
  assign f3_cond_bad = (sp_fmt == FMT_THREE) && !cond_legal(sp_cond, MAX_COND);
  assign ext_follows = (sp_fmt == FMT_ONE) && tb_ext;

  dec_t nxt;

  always_comb begin
    nxt     = '0;
    nxt.fmt = sp_fmt;
    unique case (sp_fmt)
      FMT_ONE: begin
        nxt.opc = sp_op_long;
        nxt.ra  = sp_f1_a;
        nxt.rb  = sp_f1_b;
        nxt.brk = tb_brk;
        nxt.swi = tb_swi;
        nxt.nop = tb_nop;
        nxt.am  = tb_am;
      end
      FMT_TWO: begin
        nxt.opc = OPC_W'(sp_op_sub);
        nxt.ra  = sp_f2_r;
        nxt.imm = sp_f2_imm;
      end
      default: begin
        nxt.opc = OPC_W'(sp_cond);
      end
    endcase
    nxt.ill = f1_hole_hit || f3_cond_bad;
    nxt.len = insn_len(ext_follows, nxt.ill);
  end

  dec_t q;

  hwdec_outreg u_oreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .d         (nxt),
    .out_valid (out_valid),
    .q         (q)
  );

  assign out_form    = q.fmt;
  assign out_opcode  = q.opc;
  assign out_reg_a   = q.ra;
  assign out_reg_b   = q.rb;
  assign out_imm8    = q.imm;
  assign out_len     = q.len;
  assign out_illegal = q.ill;
  assign out_brk     = q.brk;
  assign out_swi     = q.swi;
  assign out_nop     = q.nop;
  assign out_amode   = q.am;

  AST_TRAP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_brk, out_swi, out_nop}));                          // R7
  AST_AMODE_F1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_amode != 2'd0) |-> (out_form == 2'd1));                      // R8
  AST_LONG_F1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_len == 3'd6) |-> (out_form == 2'd1 && !out_illegal));        // R6
  AST_F2_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_form == 2'd2) |-> !out_illegal);                // R3
  AST_F3_NOREG: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_form == 2'd3) |-> (out_reg_a == '0 && out_imm8 == '0)); // R4

endmodule

// File: tb/halfword_decoder_bench.sv
`timescale 1ns/1ps
module halfword_decoder_bench;

  typedef struct packed {
    logic [15:0] w;
    logic [1:0]  fmt;
    logic [7:0]  opc;
    logic [3:0]  ra;
    logic [3:0]  rb;
    logic [7:0]  imm;
    logic [2:0]  len;
    logic        ill;
    logic        brk;
    logic        swi;
    logic        nop;
    logic [1:0]  am;
  } vec_t;

  localparam int NV = 21;
  // {word, form, opcode, a, b, imm, len, illegal, brk, swi, nop, amode}
  localparam logic [50:0] TBL [NV] = '{
    {16'h0123, 2'd1, 8'h01, 4'h2, 4'h3, 8'h00, 3'd6, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
    {16'h0F00, 2'd1, 8'h0F, 4'h0, 4'h0, 8'h00, 3'd2, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0},
    {16'h0000, 2'd1, 8'h00, 4'h0, 4'h0, 8'h00, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0},
    {16'h1455, 2'd1, 8'h14, 4'h5, 4'h5, 8'h00, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0},
    {16'h3500, 2'd1, 8'h35, 4'h0, 4'h0, 8'h00, 3'd2, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0},
    {16'h3000, 2'd1, 8'h30, 4'h0, 4'h0, 8'h00, 3'd6, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0},
    {16'h3A12, 2'd1, 8'h3A, 4'h1, 4'h2, 8'h00, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0},
    {16'h0C47, 2'd1, 8'h0C, 4'h4, 4'h7, 8'h00, 3'd6, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3},
    {16'h0A31, 2'd1, 8'h0A, 4'h3, 4'h1, 8'h00, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2},
    {16'h2270, 2'd1, 8'h22, 4'h7, 4'h0, 8'h00, 3'd6, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1},
    {16'h1900, 2'd1, 8'h19, 4'h0, 4'h0, 8'h00, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
    {16'h1800, 2'd1, 8'h18, 4'h0, 4'h0, 8'h00, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0},
    {16'h0918, 2'd1, 8'h09, 4'h1, 4'h8, 8'h00, 3'd6, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1},
    {16'h3918, 2'd1, 8'h39, 4'h1, 4'h8, 8'h00, 3'd6, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3},
    {16'h7FFF, 2'd1, 8'h7F, 4'hF, 4'hF, 8'h00, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0},
    {16'h85AB, 2'd2, 8'h00, 4'h5, 4'h0, 8'hAB, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
    {16'hB3FF, 2'd2, 8'h03, 4'h3, 4'h0, 8'hFF, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
    {16'hC000, 2'd3, 8'h00, 4'h0, 4'h0, 8'h00, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
    {16'hE400, 2'd3, 8'h09, 4'h0, 4'h0, 8'h00, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
    {16'hE800, 2'd3, 8'h0A, 4'h0, 4'h0, 8'h00, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0},
    {16'hFFFF, 2'd3, 8'h0F, 4'h0, 4'h0, 8'h00, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_word = 16'h0000;
  logic        out_valid;
  logic [1:0]  out_form;
  logic [7:0]  out_opcode;
  logic [3:0]  out_reg_a, out_reg_b;
  logic [7:0]  out_imm8;
  logic [2:0]  out_len;
  logic        out_illegal, out_brk, out_swi, out_nop;
  logic [1:0]  out_amode;

  int n_checks = 0;
  int n_fails  = 0;

  always #4 clk = ~clk;

  halfword_decoder u_halfword_decoder (
    .clk, .rst_n, .in_valid, .in_word, .out_valid, .out_form, .out_opcode,
    .out_reg_a, .out_reg_b, .out_imm8, .out_len, .out_illegal, .out_brk,
    .out_swi, .out_nop, .out_amode
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h (word %h)", tag, what, act, exp, in_word);
    end
  endtask

  // Bench-side model written from the requirement text.
  function automatic vec_t model(input logic [15:0] w);
    vec_t r;
    logic ext;
    r = '0;
    r.w = w;
    r.len = 3'd2;
    if (w[15] == 1'b0) begin
      r.fmt = 2'd1;
      r.opc = w[15:8];
      r.ra  = w[7:4];
      r.rb  = w[3:0];
      r.ill = (r.opc == 8'h00) || (r.opc inside {[8'h10:8'h18]}) || (r.opc > 8'h39);
      ext = r.opc inside {8'h01, 8'h03, 8'h08, 8'h09, 8'h0C, 8'h0D, 8'h1A, 8'h1B,
                          8'h1D, 8'h1F, 8'h20, 8'h22, 8'h24, 8'h30, [8'h36:8'h39]};
      if (ext && !r.ill) r.len = 3'd6;
      r.brk = (r.opc == 8'h35);
      r.swi = (r.opc == 8'h30);
      r.nop = (r.opc == 8'h0F);
      if (r.opc inside {8'h08, 8'h09, 8'h1D, 8'h1F, 8'h22, 8'h24})      r.am = 2'd1;
      else if (r.opc inside {8'h0A, 8'h0B, 8'h1C, 8'h1E, 8'h21, 8'h23}) r.am = 2'd2;
      else if (r.opc inside {8'h0C, 8'h0D, [8'h36:8'h39]})              r.am = 2'd3;
    end else if (w[14] == 1'b0) begin
      r.fmt = 2'd2;
      r.opc = {6'd0, w[13:12]};
      r.ra  = w[11:8];
      r.imm = w[7:0];
    end else begin
      r.fmt = 2'd3;
      r.opc = {4'd0, w[13:10]};
      r.ill = (w[13:10] > 4'd9);
    end
    return r;
  endfunction

  task automatic compare(input vec_t e);
    string ftag;
    ftag = (e.fmt == 2'd1) ? "R2" : (e.fmt == 2'd2) ? "R3" : "R4";
    chk("R9", "valid", 32'(out_valid), 32'd1);
    chk("R1", "form", 32'(out_form), 32'(e.fmt));
    chk(ftag, "opcode", 32'(out_opcode), 32'(e.opc));
    chk(ftag, "reg_a", 32'(out_reg_a), 32'(e.ra));
    chk(ftag, "reg_b", 32'(out_reg_b), 32'(e.rb));
    chk(ftag, "imm8", 32'(out_imm8), 32'(e.imm));
    chk((e.fmt == 2'd1) ? "R5" : ftag, "illegal", 32'(out_illegal), 32'(e.ill));
    chk("R6", "len", 32'(out_len), 32'(e.len));
    chk("R7", "brk/swi/nop", 32'({out_brk, out_swi, out_nop}), 32'({e.brk, e.swi, e.nop}));
    chk("R8", "amode", 32'(out_amode), 32'(e.am));
  endtask

  task automatic strobe(input logic [15:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "valid in reset", 32'(out_valid), 32'd0);
    chk("R10", "form in reset", 32'(out_form), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10", "all outputs after reset",
        32'({out_valid, out_opcode, out_len, out_illegal, out_amode}), 32'd0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      vec_t e;
      e = vec_t'(TBL[i]);
      strobe(e.w);
      compare(e);
    end

    // R9: idle cycle holds previous decode (last table word 16'hFFFF)
    in_word = 16'h0123;
    @(negedge clk);
    chk("R9", "valid low when idle", 32'(out_valid), 32'd0);
    chk("R9", "opcode held when idle", 32'(out_opcode), 32'h0F);
    chk("R9", "form held when idle", 32'(out_form), 32'd3);
    chk("R9", "illegal held when idle", 32'(out_illegal), 32'd1);

    // R9: back-to-back strobes, each result one cycle later
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = 16'h3000;
    @(negedge clk);
    compare(model(16'h3000));
    in_word = 16'h85AB;
    @(negedge clk);
    compare(model(16'h85AB));
    in_valid = 1'b0;

    // Sweep every upper byte against the bench model
    for (int i = 0; i < 256; i++) begin
      logic [15:0] w;
      w = {i[7:0], 8'h5A};
      strobe(w);
      compare(model(w));
    end

    // R10: mid-run reset clears everything
    strobe(16'h0C47);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R10", "len cleared by reset", 32'(out_len), 32'd0);
    chk("R10", "amode cleared by reset", 32'(out_amode), 32'd0);
    chk("R10", "form cleared by reset", 32'(out_form), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule